// File: doc/BRIEF.md
# Clock Activity Monitor

This block runs on a free-running system clock and watches three clocks that come from other sources: a transmit clock, a receive clock and a reference clock. For each one it keeps a fault bit. The bit is 1 when no edge was seen during the last observation window and 0 when at least one edge was seen. The block only checks for activity. It never estimates a frequency.

The block also keeps a second, sticky indication: a low-rate flag for the transmit cell-bus byte clock. The flag is raised whenever more than 128 system clocks pass without a transmit edge. Software reads the fault bits and the flag through a one-bit-address read port. It clears the flag by writing a zero to it.

Each monitored clock toggles a flop in its own domain. The toggle is carried into the system domain through a two-stage synchronizer, and every change of the synchronized toggle counts as one edge.

Top module: `clock_activity_monitor`

## Requirements
- R1: After reset, address 0 reads 8'h07 (all three clocks faulty) and address 1 reads 8'h00 (low-rate flag clear).
- R2: Address 0 holds the fault bits: bit 0 for the transmit clock, bit 1 for the receive clock and bit 2 for the reference clock. Address 1 holds the low-rate flag in bit 0. All other read bits are 0.
- R3: The fault bits change only at the end of each 256-system-clock observation window. A clock with at least one detected edge in the window reads 0. A clock with no detected edge reads 1.
- R4: Each clock is judged on its own. Stopping one clock sets only its own fault bit.
- R5: The low-rate flag is set when more than 128 system clocks pass with no detected transmit edge. It stays clear while transmit edges come at most 128 system clocks apart.
- R6: The low-rate flag is sticky. It is cleared only by a write to address 1 with data bit 0 equal to 0. If the low-rate condition holds in the same cycle as the write, the flag stays set.
- R7: A write with data bit 0 equal to 1, or a write to address 0, leaves the low-rate flag unchanged.
- R8: The low-rate flag and the transmit fault bit are independent. A transmit clock slower than the threshold, but still active in each window, reads fault 0 while its flag is 1.
- R9: The monitored clocks are asynchronous to the system clock, and none runs faster than it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock |
| sysRstN | input | 1 | Asynchronous active-low reset |
| txClk | input | 1 | Monitored transmit clock |
| rxClk | input | 1 | Monitored receive clock |
| refClk | input | 1 | Monitored reference clock |
| rdAddr | input | 1 | Read select: 0 = fault bits, 1 = low-rate flag |
| rdData | output | 8 | Read data for rdAddr (combinational) |
| wrEn | input | 1 | Write strobe, one system clock wide |
| wrAddr | input | 1 | Write address; only address 1 has an effect |
| wrData | input | 8 | Write data; bit 0 equal to 0 clears the flag |

## Verification
The bench first runs all three clocks at unrelated rates, then stops them one at a time and all together. This shows that each fault bit follows its own clock and that a stopped clock is not masked by the others.

Transmit periods of about 120 and 140 system clocks sit on either side of the 128-cycle threshold, so the flag's boundary is tested. A period of 240 system clocks separates the low-rate flag from the activity bit.

Writes of 1, writes to the wrong address and a clear issued while the condition persists show which writes actually reset the sticky flag.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int NUM_CLK   = 3;
  localparam int WIN_LOG2  = 8;
  localparam int RATE_LOG2 = 7;
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic windowEnd;
    logic lowRateHit;
    logic clearLow;
  } camStrobe_t;
endpackage

// File: rtl/cam_edge_sync.sv
module cam_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic monClk,
  input  logic sysClk,
  input  logic rstN,
  output logic edgePulse
);
  logic togQ;
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge monClk or negedge rstN) begin
    if (!rstN) togQ <= 1'b0;
    else       togQ <= ~togQ;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], togQ};
  end

  assign edgePulse = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
#(
  parameter int WIN_BITS  = WIN_LOG2,
  parameter int RATE_BITS = RATE_LOG2
) (
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       txEdge,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic       wrBit0,
  output camStrobe_t strb
);
  logic [WIN_BITS-1:0]  winCnt;
  logic [RATE_BITS-1:0] lowCnt;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else       winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)        lowCnt <= '0;
    else if (txEdge)  lowCnt <= '0;
    else if (!(&lowCnt)) lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    strb.windowEnd  = &winCnt;
    strb.lowRateHit = (&lowCnt) & ~txEdge;
    strb.clearLow   = wrEn & wrAddr & ~wrBit0;
  end

  // R3: a window closes in a single cycle
  a_r3_window_single: assert property (@(posedge sysClk) disable iff (!rstN)
    strb.windowEnd |=> !strb.windowEnd);
  // R5: a detected transmit edge restarts the low-rate count
  a_r5_edge_restarts: assert property (@(posedge sysClk) disable iff (!rstN)
    txEdge |=> !strb.lowRateHit);
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int N_CLK  = NUM_CLK,
  parameter int DWIDTH = DATA_W
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic [N_CLK-1:0]  edges,
  input  camStrobe_t        strb,
  input  logic              rdAddr,
  output logic [DWIDTH-1:0] rdData
);
  logic [N_CLK-1:0] seenQ;
  logic [N_CLK-1:0] faultQ;
  logic             lowFlagQ;

  for (genvar i = 0; i < N_CLK; i++) begin : g_chan
    always_ff @(posedge sysClk or negedge rstN) begin
      if (!rstN) begin
        seenQ[i]  <= 1'b0;
        faultQ[i] <= 1'b1;
      end else if (strb.windowEnd) begin
        seenQ[i]  <= 1'b0;
        faultQ[i] <= ~(seenQ[i] | edges[i]);
      end else begin
        seenQ[i]  <= seenQ[i] | edges[i];
      end
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                lowFlagQ <= 1'b0;
    else if (strb.lowRateHit) lowFlagQ <= 1'b1;
    else if (strb.clearLow)   lowFlagQ <= 1'b0;
  end

  assign rdData = rdAddr ? DWIDTH'(lowFlagQ) : DWIDTH'(faultQ);

  // R3: fault bits move only when a window closes
  a_r3_stable_inside_window: assert property (@(posedge sysClk) disable iff (!rstN)
    !strb.windowEnd |=> $stable(faultQ));
  // R5: a low-rate hit always leaves the flag set
  a_r5_hit_sets_flag: assert property (@(posedge sysClk) disable iff (!rstN)
    strb.lowRateHit |=> lowFlagQ);
  // R6: without a clear strobe the flag never falls
  a_r6_flag_sticky: assert property (@(posedge sysClk) disable iff (!rstN)
    (lowFlagQ && !strb.clearLow) |=> lowFlagQ);
endmodule

// File: rtl/clock_activity_monitor.sv
module clock_activity_monitor
  import cam_pkg::*;
(
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic              txClk,
  input  logic              rxClk,
  input  logic              refClk,
  input  logic              rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  logic [NUM_CLK-1:0] monClks;
  logic [NUM_CLK-1:0] edges;
  camStrobe_t         strb;

  assign monClks = {refClk, rxClk, txClk};

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_sync
    cam_edge_sync #(.SYNC_STAGES(2)) u_sync (
      .monClk   (monClks[i]),
      .sysClk   (sysClk),
      .rstN     (sysRstN),
      .edgePulse(edges[i])
    );
  end

  cam_ctrl u_ctrl (
    .sysClk(sysClk),
    .rstN  (sysRstN),
    .txEdge(edges[0]),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrBit0(wrData[0]),
    .strb  (strb)
  );

  cam_datapath u_dp (
    .sysClk(sysClk),
    .rstN  (sysRstN),
    .edges (edges),
    .strb  (strb),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  // R2: read bits beyond the defined fields are zero
  a_r2_unused_bits_zero: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (rdData >> NUM_CLK) == '0);
endmodule

// File: tb/clock_activity_monitor_tb.sv
`timescale 1ns/1ps
module clock_activity_monitor_tb;
  typedef struct {
    logic       addr;
    logic [7:0] val;
    string      tag;
  } expItem_t;

  logic sysClk = 1'b0, sysRstN = 1'b0;
  logic txClk = 1'b0, rxClk = 1'b0, refClk = 1'b0;
  logic rdAddr = 1'b0, wrEn = 1'b0, wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  bit txOn = 0, rxOn = 0, refOn = 0;
  int txHalf = 23, rxHalf = 37, refHalf = 13;
  int checks = 0, fails = 0;
  bit done = 0;
  expItem_t expQ[$];

  clock_activity_monitor u_dut (
    .sysClk(sysClk), .sysRstN(sysRstN), .txClk(txClk), .rxClk(rxClk),
    .refClk(refClk), .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  always #2.5 sysClk = ~sysClk;
  initial forever begin #(txHalf);  if (txOn)  txClk  = ~txClk;  end
  initial forever begin #(rxHalf);  if (rxOn)  rxClk  = ~rxClk;  end
  initial forever begin #(refHalf); if (refOn) refClk = ~refClk; end

  // monitor: pops each expected item and compares it with the read port
  initial forever begin
    @(negedge sysClk);
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      rdAddr = it.addr;
      #1;
      checks++;
      if (rdData !== it.val) begin
        fails++;
        $display("FAIL %s: addr %0d actual %02h expected %02h", it.tag, it.addr, rdData, it.val);
      end
    end
  end

  task automatic expectRd(input logic a, input logic [7:0] v, input string tag);
    expItem_t it;
    it.addr = a; it.val = v; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    @(negedge sysClk);
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge sysClk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge sysClk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  initial begin
    idle(3);
    // R1: reset values
    expectRd(1'b0, 8'h07, "R1 faults after reset");
    expectRd(1'b1, 8'h00, "R1 flag after reset");
    sysRstN = 1'b1;
    expectRd(1'b0, 8'h07, "R1 faults before first window");
    // R3 R9: all clocks active at unrelated rates
    txOn = 1; rxOn = 1; refOn = 1;
    idle(600);
    expectRd(1'b0, 8'h00, "R3 all active");
    expectRd(1'b1, 8'h00, "R5 fast tx keeps flag clear");
    // R4: stop receive only
    rxOn = 0;
    idle(600);
    expectRd(1'b0, 8'h02, "R4 rx stopped alone");
    // R3 R2: stop all
    txOn = 0; refOn = 0;
    idle(600);
    expectRd(1'b0, 8'h07, "R3 all stopped");
    expectRd(1'b1, 8'h01, "R5 stopped tx sets flag");
    // R7: ineffective writes
    wrReg(1'b1, 8'hFF);
    expectRd(1'b1, 8'h01, "R7 write one keeps flag");
    wrReg(1'b0, 8'h00);
    expectRd(1'b1, 8'h01, "R7 write addr0 keeps flag");
    // R6: clear while condition persists, then clear with tx running
    wrReg(1'b1, 8'h00);
    expectRd(1'b1, 8'h01, "R6 set wins over clear");
    txOn = 1; txHalf = 23;
    idle(50);
    wrReg(1'b1, 8'hFE);
    expectRd(1'b1, 8'h00, "R6 clear by write zero");
    idle(600);
    expectRd(1'b0, 8'h06, "R4 tx back, rx ref stopped");
    expectRd(1'b1, 8'h00, "R6 flag remains clear");
    // R5 boundary: period of 120 system clocks stays clear
    txHalf = 300;
    idle(300);
    wrReg(1'b1, 8'h00);
    idle(1000);
    expectRd(1'b1, 8'h00, "R5 period 120 below threshold");
    // R5: period of 140 system clocks sets flag
    txHalf = 350;
    idle(1000);
    expectRd(1'b1, 8'h01, "R5 period 140 above threshold");
    // R8: period of 240 still active but slow
    txHalf = 600;
    idle(600);
    wrReg(1'b1, 8'h00);
    idle(1500);
    expectRd(1'b1, 8'h01, "R8 slow tx flag set");
    expectRd(1'b0, 8'h06, "R8 slow tx still active");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule